// File: doc/BRIEF.md
# Level-Sensed External Interrupt Aggregator

This block collects eight external interrupt pins and presents them to a processor interrupt controller as a single request with a single priority. Each pin crosses into the clock domain through a two-flop synchroniser. It then passes through its own enable gate and its own polarity select. The enabled, active pins are ORed into one group request.

The request is level-sensed. It stays asserted for as long as at least one enabled pin holds its active level. It drops once the external source releases the pin. Software must therefore clear the cause at the source before it leaves its service routine.

A small register interface lets software program the per-pin enable and polarity bits and the shared 4-bit priority, and read back which pins are currently requesting. When the processor accepts the request, the block pulses a load strobe carrying the group priority. The processor copies this value into its interrupt mask.

Top module: `ext_irq_aggregator`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registers clear to zero. After such an edge, the control and priority reads return 0, `irq_req` is 0 and `mask_load` is 0.
- R2: A change on `pin_in` is first visible in the status read on the second rising clock edge after the change, and not on the first.
- R3: With a pin's sense bit at 0 (low sense) and its enable bit at 1, its status bit is 1 while the pin is low and 0 while it is high.
- R4: With a pin's sense bit at 1 (high sense) and its enable bit at 1, its status bit is 1 while the pin is high and 0 while it is low.
- R5: A pin whose enable bit is 0 reads 0 in status and never causes `irq_req`, whatever its level.
- R6: `irq_req` is 1 exactly when at least one status bit is 1 and the priority is non-zero. Priority 0 masks the group.
- R7: Register address 0 (control) holds the enables in bits 7..0 and the sense selects in bits 15..8. Bit i of each field belongs to pin i. The register reads back as written.
- R8: Register address 1 (priority) holds the group priority in bits 15..12. Its other bits are not stored and read as 0.
- R9: Register address 2 (status) holds one bit per pin in bits 7..0. Writes to address 2 change no register and no status bit. Address 3 reads 0.
- R10: If `irq_ack` is 1 at a clock edge while `irq_req` is 1, then `mask_load` is 1 for the following cycle with `mask_level` equal to the priority. An acknowledge without a request produces no `mask_load`.
- R11: Once every requesting pin returns to its inactive level, `irq_req` drops two clock edges later, with no clear operation needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 8 | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 priority, 2 status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| irq_ack | input | 1 | Processor accepts the pending request |
| irq_req | output | 1 | Group interrupt request |
| irq_level | output | 4 | Group priority presented with the request |
| mask_load | output | 1 | One-cycle strobe after an accepted request |
| mask_level | output | 4 | Priority to load into the processor mask |

## Verification
The assertions check on every cycle that the synchronised levels equal the pin levels from two edges before, and that a request never appears at priority 0. They also check that a write to the status address leaves control and priority untouched, and that every accept yields exactly one load strobe carrying the priority. The bench scenarios are needed to show the polarity mapping of each sense value and the exclusion of disabled pins. They also show the bit layout of the control and priority registers and the release of the request once the pins go inactive. These depend on register contents that only a programmed sequence can establish.

// File: rtl/eia_pkg.sv
// Shared constants and the register address map for the interrupt aggregator.
// Assumes a 16-bit register interface with word addresses.
package eia_pkg;
    localparam int PIN_COUNT = 8;
    localparam int PRIO_W    = 4;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_PRIO = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/eia_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous pins.
// Assumes each pin is a slow level, so no bus coherence is needed.
module eia_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] chain_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pin levels one stage deeper each clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= '0;
                else if (g == 0) chain_q[g] <= async_in;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            logic [1:0] warm_q;
            // Count edges since reset so the latency check looks back only into valid history.
            always_ff @(posedge clk) begin
                if (!rst_n) warm_q <= '0;
                else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
            end
            // R2
            sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd3) |-> (sync_out == $past(async_in, 2)));
        end
    endgenerate
endmodule

// File: rtl/eia_regs.sv
// Software-visible registers: control (enables and senses), priority, status.
// Assumes a single-cycle write strobe and a combinational read.
module eia_regs
    import eia_pkg::*;
#(
    parameter int N     = PIN_COUNT,
    parameter int PW    = PRIO_W,
    parameter int RW    = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RW-1:0]     wdata,
    input  logic [N-1:0]      status,
    output logic [N-1:0]      enable,
    output logic [N-1:0]      sense,
    output logic [PW-1:0]     prio,
    output logic [RW-1:0]     rdata
);
    localparam int PRIO_LSB = RW - PW;

    logic [N-1:0]  enable_q;
    logic [N-1:0]  sense_q;
    logic [PW-1:0] prio_q;

    // Store control and priority fields on writes to their addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            sense_q  <= '0;
            prio_q   <= '0;
        end else if (wr) begin
            if (addr == ADDR_CTRL) begin
                enable_q <= wdata[N-1:0];
                sense_q  <= wdata[2*N-1:N];
            end else if (addr == ADDR_PRIO) begin
                prio_q   <= wdata[RW-1:PRIO_LSB];
            end
        end
    end

    // Select the read word for the current address.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[N-1:0]   = enable_q;
                rdata[2*N-1:N] = sense_q;
            end
            ADDR_PRIO: rdata[RW-1:PRIO_LSB] = prio_q;
            ADDR_STAT: rdata[N-1:0]         = status;
            default:   rdata = '0;
        endcase
    end

    assign enable = enable_q;
    assign sense  = sense_q;
    assign prio   = prio_q;

    // R9
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_STAT) |=> ($stable(enable_q) && $stable(sense_q) && $stable(prio_q)));
endmodule

// File: rtl/eia_detect.sv
// Per-pin level detection: polarity select, enable gating, group OR.
// Assumes synchronised pin levels; sense 0 means active low.
module eia_detect #(
    parameter int N = 8
) (
    input  logic [N-1:0] pin_sync,
    input  logic [N-1:0] enable,
    input  logic [N-1:0] sense,
    output logic [N-1:0] status,
    output logic         any_active
);
    genvar p;
    generate
        for (p = 0; p < N; p++) begin : g_pin
            // A pin requests when enabled and its level matches its sense select.
            always_comb status[p] = enable[p] && (pin_sync[p] == sense[p]);
        end
    endgenerate

    // Combine all pin requests into one group request.
    always_comb any_active = |status;
endmodule

// File: rtl/ext_irq_aggregator.sv
// Eight-pin level-sensed interrupt aggregator with one shared priority.
// Assumes asynchronous pins, synchronous active-low reset, and a processor
// that raises irq_ack for one cycle when it takes the request.
module ext_irq_aggregator
    import eia_pkg::*;
#(
    parameter int N_PINS   = PIN_COUNT,
    parameter int PRIO_BITS = PRIO_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_PINS-1:0]    pin_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 irq_ack,
    output logic                 irq_req,
    output logic [PRIO_BITS-1:0] irq_level,
    output logic                 mask_load,
    output logic [PRIO_BITS-1:0] mask_level
);
    logic [N_PINS-1:0]    pin_sync;
    logic [N_PINS-1:0]    enable;
    logic [N_PINS-1:0]    sense;
    logic [N_PINS-1:0]    status;
    logic [PRIO_BITS-1:0] prio;
    logic                 any_active;
    logic                 load_q;
    logic [PRIO_BITS-1:0] level_q;

    eia_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    eia_regs #(.N(N_PINS), .PW(PRIO_BITS), .RW(REG_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .status (status),
        .enable (enable),
        .sense  (sense),
        .prio   (prio),
        .rdata  (reg_rdata)
    );

    eia_detect #(.N(N_PINS)) u_detect (
        .pin_sync   (pin_sync),
        .enable     (enable),
        .sense      (sense),
        .status     (status),
        .any_active (any_active)
    );

    // Raise the group request only when some pin is active and the group is unmasked.
    always_comb irq_req = any_active && (prio != '0);
    assign irq_level = prio;

    // Capture the priority as a one-cycle mask load when the processor accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= 1'b0;
            level_q <= '0;
        end else begin
            load_q  <= irq_ack && irq_req;
            if (irq_ack && irq_req) level_q <= prio;
        end
    end

    assign mask_load  = load_q;
    assign mask_level = level_q;

    // R6
    prio_zero_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio == '0) |-> !irq_req);

    // R10
    ack_loads_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (mask_load && mask_level == $past(prio)));

    // R10
    no_spurious_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq_req) |=> !mask_load);
endmodule

// File: tb/ext_irq_aggregator_tb.sv
module ext_irq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_in = 8'hFF;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [3:0]  irq_level;
    logic        mask_load;
    logic [3:0]  mask_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ext_irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_level(irq_level), .mask_load(mask_load), .mask_level(mask_level)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rst_n = 1'b0;
        repeat (3) tick();
        rd(2'd0, d); check(d == 16'h0, "R1 ctrl", d, 0);
        rd(2'd1, d); check(d == 16'h0, "R1 prio", d, 0);
        check(irq_req == 1'b0, "R1 irq_req", irq_req, 0);
        check(mask_load == 1'b0, "R1 mask_load", mask_load, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(2'd0, 16'hA55A);
        rd(2'd0, d); check(d == 16'hA55A, "R7 ctrl readback", d, 16'hA55A);
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check(d == 16'hF000, "R8 prio field", d, 16'hF000);
        check(irq_level == 4'hF, "R8 irq_level", irq_level, 4'hF);
        rd(2'd3, d); check(d == 16'h0, "R9 addr3 zero", d, 0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0000);
    endtask

    task automatic t_low_sense();
        logic [15:0] d;
        pin_in = 8'hFF;
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h5000);
        tick(); tick();
        pin_in[0] = 1'b0;
        tick();
        rd(2'd2, d); check(d == 16'h0000, "R2 not yet after one edge", d, 0);
        tick();
        rd(2'd2, d); check(d == 16'h0001, "R2 R3 low active after two edges", d, 1);
        check(irq_req == 1'b1, "R6 request with prio 5", irq_req, 1);
        pin_in[0] = 1'b1;
        tick();
        check(irq_req == 1'b1, "R11 still held one edge later", irq_req, 1);
        tick();
        check(irq_req == 1'b0, "R11 released two edges later", irq_req, 0);
        rd(2'd2, d); check(d == 16'h0000, "R3 high is inactive", d, 0);
    endtask

    task automatic t_high_sense();
        logic [15:0] d;
        pin_in = 8'h00;
        wr(2'd0, 16'h8080);
        tick(); tick();
        rd(2'd2, d); check(d == 16'h0000, "R4 low is inactive", d, 0);
        pin_in[7] = 1'b1;
        tick(); tick();
        rd(2'd2, d); check(d == 16'h0080, "R4 high active", d, 16'h80);
        check(irq_req == 1'b1, "R4 request", irq_req, 1);
        pin_in = 8'hFF;
    endtask

    task automatic t_disabled();
        logic [15:0] d;
        pin_in = 8'h00;
        wr(2'd0, 16'h000F);
        tick(); tick();
        rd(2'd2, d); check(d == 16'h000F, "R5 only enabled pins", d, 16'h0F);
        wr(2'd0, 16'h0000);
        tick();
        rd(2'd2, d); check(d == 16'h0000, "R5 all disabled", d, 0);
        check(irq_req == 1'b0, "R5 no request", irq_req, 0);
    endtask

    task automatic t_prio_zero();
        pin_in = 8'h00;
        wr(2'd0, 16'h00FF);
        wr(2'd1, 16'h0000);
        tick(); tick();
        check(irq_req == 1'b0, "R6 prio zero masks", irq_req, 0);
        wr(2'd1, 16'h9000);
        check(irq_req == 1'b1, "R6 prio nine requests", irq_req, 1);
        check(irq_level == 4'h9, "R6 irq_level", irq_level, 9);
    endtask

    task automatic t_status_ro();
        logic [15:0] d;
        wr(2'd2, 16'hFFFF);
        rd(2'd0, d); check(d == 16'h00FF, "R9 ctrl unchanged", d, 16'h00FF);
        rd(2'd1, d); check(d == 16'h9000, "R9 prio unchanged", d, 16'h9000);
        rd(2'd2, d); check(d == 16'h00FF, "R9 status unchanged", d, 16'h00FF);
    endtask

    task automatic t_ack();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        check(mask_load == 1'b1, "R10 load strobe", mask_load, 1);
        check(mask_level == 4'h9, "R10 load level", mask_level, 9);
        tick();
        check(mask_load == 1'b0, "R10 single cycle", mask_load, 0);
        wr(2'd0, 16'h0000);
        check(irq_req == 1'b0, "R10 no request", irq_req, 0);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        check(mask_load == 1'b0, "R10 ack without request", mask_load, 0);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_low_sense();
        t_high_sense();
        t_disabled();
        t_prio_zero();
        t_status_ro();
        t_ack();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule